// File: doc/BRIEF.md
# Bus Self-Test Register Slave

This block is a small Wishbone slave that answers on a 3-bit word address. It lets a bus master or bridge try every response path it has. Two addresses return fixed identification and version words. A group of test addresses holds three registers: an ordinary read/write register, a write-only register and a read-only mirror of that write-only value. Accesses in the wrong direction answer with a bus error. One address never answers, so the master's timeout logic has to step in. Reserved addresses answer with an error.

A parameter switches the test group on or off. With it off, only the identification and version words answer normally, and every other address returns an error.

The handshake is the classic single-cycle form and the block never stalls. A request is taken on the first clock edge at which `cyc_i` and `stb_i` are both high. The response is a one-cycle pulse on `ack_o` or `err_o` in the next cycle. The block takes no new request until the strobe has been low for at least one edge. A master that keeps the strobe high after the response therefore gets exactly one response. On the address that never answers, the master holds the strobe until it gives up.

Top module: `wb_selftest_slave`

## Requirements
- R1: Address 0 is the identification word. A read answers with ack and `dat_o` = 0x1ED91FCA. A write answers with ack and changes nothing.
- R2: Address 1 is the version word. A read answers with ack and `dat_o` = 0xD4880D94. A write answers with ack and changes nothing.
- R3: Address 4 is a 32-bit read/write register. Reads and writes are acknowledged. On a write, byte lane i (bits 8i+7..8i) is updated only when `sel_i[i]` is 1.
- R4: Address 5 is write-only. A write stores data under the same byte-lane rule as R3 and answers with ack. A read answers with err.
- R5: Address 6 is read-only. A read answers with ack and returns the current address-5 value. A write answers with err and leaves both registers unchanged.
- R6: Address 7 never raises ack or err, for reads or for writes, however long the strobe is held.
- R7: Addresses 2 and 3 answer with err. Every err cycle drives `dat_o` = 0xA5A5A5A5.
- R8: ack and err are never high together. A response is a single-cycle pulse in the cycle after the edge that accepted the request. No further response is given until the strobe has been low for at least one edge.
- R9: After reset, ack and err are low and the address-4 and address-5 registers read as zero.
- R10: With `TEST_EN` = 0, addresses 0 and 1 behave as in R1 and R2, and addresses 2 to 7 all answer with err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe: request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 3 | Word address |
| dat_i | input | 32 | Write data |
| sel_i | input | 4 | Byte-lane enables for writes |
| dat_o | output | 32 | Read data; 0xA5A5A5A5 during err; 0 otherwise |
| ack_o | output | 1 | Normal completion pulse |
| err_o | output | 1 | Error completion pulse |

## Verification
The assertions check on every cycle the handshake rules that hold for any address. ack and err never overlap. A response lasts one cycle and always follows an accepted request. The never-answering address stays silent. The write-only value holds unless a write to address 5 is accepted. The bench scenarios show the things that depend on values. These are the constant words, the byte-lane merges over all sixteen select patterns, the read-only mirror, the fill word on errors, the reset contents, and the decode with the test group switched off, which a second instance covers.

// File: rtl/wbst_pkg.sv
package wbst_pkg;
  localparam int ADR_W = 3;
  localparam int DAT_W = 32;

  localparam logic [DAT_W-1:0] ID_WORD   = 32'h1ED91FCA;
  localparam logic [DAT_W-1:0] VER_WORD  = 32'hD4880D94;
  localparam logic [DAT_W-1:0] FILL_WORD = 32'hA5A5A5A5;

  typedef enum logic [ADR_W-1:0] {
    SLOT_ID   = 3'd0,
    SLOT_VER  = 3'd1,
    SLOT_RSV2 = 3'd2,
    SLOT_RSV3 = 3'd3,
    SLOT_RW   = 3'd4,
    SLOT_WO   = 3'd5,
    SLOT_RO   = 3'd6,
    SLOT_HANG = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    RESP_NONE = 2'd0,
    RESP_ACK  = 2'd1,
    RESP_ERR  = 2'd2
  } resp_e;
endpackage

// File: rtl/wbst_decode.sv
module wbst_decode
  import wbst_pkg::*;
#(
  parameter bit TEST_EN = 1'b1
) (
  input  logic [ADR_W-1:0] adr,
  input  logic             we,
  output resp_e            resp,
  output logic             hit_rw_wr,
  output logic             hit_wo_wr
);
  always_comb begin
    resp      = RESP_ERR;
    hit_rw_wr = 1'b0;
    hit_wo_wr = 1'b0;
    unique case (slot_e'(adr))
      SLOT_ID, SLOT_VER: resp = RESP_ACK;
      SLOT_RW: if (TEST_EN) begin
        resp      = RESP_ACK;
        hit_rw_wr = we;
      end
      SLOT_WO: if (TEST_EN) begin
        resp      = we ? RESP_ACK : RESP_ERR;
        hit_wo_wr = we;
      end
      SLOT_RO: if (TEST_EN) resp = we ? RESP_ERR : RESP_ACK;
      SLOT_HANG: if (TEST_EN) resp = RESP_NONE;
      default: resp = RESP_ERR;
    endcase
  end
endmodule

// File: rtl/wbst_regs.sv
module wbst_regs #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_rw,
  input  logic            wr_wo,
  input  logic [DW-1:0]   wdat,
  input  logic [DW/8-1:0] sel,
  output logic [DW-1:0]   rw_q,
  output logic [DW-1:0]   wo_q
);
  localparam int NB = DW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rw_q[8*i +: 8] <= '0;
        wo_q[8*i +: 8] <= '0;
      end else begin
        if (wr_rw && sel[i]) rw_q[8*i +: 8] <= wdat[8*i +: 8];
        if (wr_wo && sel[i]) wo_q[8*i +: 8] <= wdat[8*i +: 8];
      end
    end
  end

  // R5: the mirrored value only moves on an accepted write to address 5
  p_wo_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_wo |=> $stable(wo_q));
  // R3: the read/write register only moves on its own write
  p_rw_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_rw |=> $stable(rw_q));
endmodule

// File: rtl/wbst_hs.sv
module wbst_hs
  import wbst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cyc,
  input  logic  stb,
  input  resp_e resp,
  output logic  accept,
  output logic  ack,
  output logic  err
);
  logic done_q;

  assign accept = cyc && stb && !done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ack    <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (!(cyc && stb)) done_q <= 1'b0;
      else if (accept)   done_q <= 1'b1;
      ack <= accept && (resp == RESP_ACK);
      err <= accept && (resp == RESP_ERR);
    end
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(ack && err));
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (ack || err) |=> !(ack || err));
  p_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (ack || err) |-> $past(cyc && stb));
endmodule

// File: rtl/wb_selftest_slave.sv
module wb_selftest_slave
  import wbst_pkg::*;
#(
  parameter bit TEST_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                cyc_i,
  input  logic                stb_i,
  input  logic                we_i,
  input  logic [ADR_W-1:0]    adr_i,
  input  logic [DAT_W-1:0]    dat_i,
  input  logic [DAT_W/8-1:0]  sel_i,
  output logic [DAT_W-1:0]    dat_o,
  output logic                ack_o,
  output logic                err_o
);
  resp_e             resp;
  logic              hit_rw_wr, hit_wo_wr, accept;
  logic [DAT_W-1:0]  rw_q, wo_q, rdata;

  wbst_decode #(.TEST_EN(TEST_EN)) u_dec (
    .adr(adr_i), .we(we_i), .resp(resp),
    .hit_rw_wr(hit_rw_wr), .hit_wo_wr(hit_wo_wr)
  );

  wbst_regs #(.DW(DAT_W)) u_regs (
    .clk(clk_i), .rst(rst_i),
    .wr_rw(accept && hit_rw_wr), .wr_wo(accept && hit_wo_wr),
    .wdat(dat_i), .sel(sel_i), .rw_q(rw_q), .wo_q(wo_q)
  );

  wbst_hs u_hs (
    .clk(clk_i), .rst(rst_i), .cyc(cyc_i), .stb(stb_i), .resp(resp),
    .accept(accept), .ack(ack_o), .err(err_o)
  );

  always_comb begin
    unique case (slot_e'(adr_i))
      SLOT_ID:  rdata = ID_WORD;
      SLOT_VER: rdata = VER_WORD;
      SLOT_RW:  rdata = rw_q;
      SLOT_RO:  rdata = wo_q;
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                                dat_o <= '0;
    else if (accept && resp == RESP_ACK)      dat_o <= rdata;
    else if (accept && resp == RESP_ERR)      dat_o <= FILL_WORD;
    else                                      dat_o <= '0;
  end

  p_hang_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (TEST_EN && accept && adr_i == 3'd7) |=> !(ack_o || err_o));
  p_fill_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> (dat_o == FILL_WORD));
  p_ro_wr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (accept && we_i && adr_i == 3'd6) |=> ($stable(wo_q) && $stable(rw_q)));
endmodule

// File: tb/tb_wb_selftest_slave.sv
module tb_wb_selftest_slave;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [2:0] adr = '0;
  logic [31:0] dat = '0;
  logic [3:0] sel = '0;
  logic [31:0] d1, d0;
  logic a1, e1, a0, e0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_selftest_slave #(.TEST_EN(1'b1)) dut (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(dat), .sel_i(sel), .dat_o(d1), .ack_o(a1), .err_o(e1));
  wb_selftest_slave #(.TEST_EN(1'b0)) dut_off (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .dat_i(dat), .sel_i(sel), .dat_o(d0), .ack_o(a0), .err_o(e0));

  logic [31:0] rw_m = '0, wo_m = '0;
  logic r1a, r1e, r0a, r0e;
  logic [31:0] r1d, r0d;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [2:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; dat = d; sel = s;
    @(posedge clk); #1;
    r1a = a1; r1e = e1; r1d = d1; r0a = a0; r0e = e0; r0d = d0;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0;
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] s);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{s[i]}};
    return m;
  endfunction

  // expected {ack,err} for the enabled instance
  function automatic logic [1:0] kind_on(input logic w, input logic [2:0] a);
    case (a)
      0, 1, 4: return 2'b10;
      5: return w ? 2'b10 : 2'b01;
      6: return w ? 2'b01 : 2'b10;
      7: return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R9 ack/err idle", {30'd0, a1, e1}, 32'd0);
    xfer(0, 3'd4, 0, 0); chk("R9 rw reset", r1d, 32'd0);
    xfer(0, 3'd6, 0, 0); chk("R9 wo reset", r1d, 32'd0);

    // sweep every address and direction on both instances
    for (int w = 0; w < 2; w++) begin
      for (int a = 0; a < 8; a++) begin
        logic [31:0] pat;
        logic [1:0] k;
        pat = 32'h0101_0101 * (a + 1) + 32'h1000_0000 * w;
        k = kind_on(w[0], a[2:0]);
        xfer(w[0], a[2:0], pat, 4'hF);
        chk("R8 ack/err kind", {30'd0, r1a, r1e}, {30'd0, k});
        chk("R10 disabled kind", {30'd0, r0a, r0e}, (a < 2) ? 32'd2 : 32'd1);
        if (k == 2'b01) chk("R7 fill on err", r1d, 32'hA5A5A5A5);
        if (a >= 2) chk("R7 fill disabled", r0d, 32'hA5A5A5A5);
        if (w == 0 && a == 0) chk("R1 id", r1d, 32'h1ED91FCA);
        if (w == 0 && a == 1) chk("R2 ver", r1d, 32'hD4880D94);
        if (w == 0 && a == 4) chk("R3 rw read", r1d, rw_m);
        if (w == 0 && a == 6) chk("R5 ro read", r1d, wo_m);
        if (w == 1 && a == 4) rw_m = pat;
        if (w == 1 && a == 5) wo_m = pat;
      end
    end
    xfer(0, 3'd0, 0, 0); chk("R1 id after write", r1d, 32'h1ED91FCA);
    xfer(0, 3'd1, 0, 0); chk("R2 ver after write", r1d, 32'hD4880D94);
    xfer(0, 3'd4, 0, 0); chk("R3 rw after sweep", r1d, rw_m);
    xfer(0, 3'd6, 0, 0); chk("R5 ro unchanged by write", r1d, wo_m);

    // byte-lane sweep over all select patterns
    for (int s = 0; s < 16; s++) begin
      logic [31:0] v, m;
      v = {8'(s * 17 + 3), 8'(s * 5 + 9), 8'(s * 29 + 1), 8'(s * 11 + 7)};
      m = lanes(s[3:0]);
      xfer(1, 3'd4, v, s[3:0]); rw_m = (rw_m & ~m) | (v & m);
      xfer(0, 3'd4, 0, 0); chk("R3 byte lanes", r1d, rw_m);
      xfer(1, 3'd5, ~v, s[3:0]); wo_m = (wo_m & ~m) | (~v & m);
      chk("R4 wo write ack", {31'd0, r1a}, 32'd1);
      xfer(0, 3'd6, 0, 0); chk("R4 mirror lanes", r1d, wo_m);
      xfer(1, 3'd6, v, 4'hF); chk("R5 ro write err", {30'd0, r1a, r1e}, 32'd1);
      xfer(0, 3'd6, 0, 0); chk("R5 ro write no effect", r1d, wo_m);
      xfer(0, 3'd4, 0, 0); chk("R5 rw untouched", r1d, rw_m);
    end

    // hang address: strobe held 20 cycles, no response
    for (int w = 0; w < 2; w++) begin
      int seen;
      seen = 0;
      @(negedge clk); cyc = 1; stb = 1; we = w[0]; adr = 3'd7; dat = '1; sel = 4'hF;
      repeat (20) begin @(posedge clk); #1; if (a1 || e1) seen++; end
      @(negedge clk); cyc = 0; stb = 0; we = 0;
      chk("R6 hang silent", seen, 0);
    end

    // strobe held after a response: exactly one pulse, one cycle after accept
    for (int a = 0; a < 4; a++) begin
      int pulses, first;
      pulses = 0; first = -1;
      @(negedge clk); cyc = 1; stb = 1; we = 0; adr = a[2:0];
      for (int c = 0; c < 6; c++) begin
        @(posedge clk); #1;
        if (a1 || e1) begin pulses++; if (first < 0) first = c; end
      end
      @(negedge clk); cyc = 0; stb = 0;
      chk("R8 single pulse", pulses, 1);
      chk("R8 pulse timing", first, 0);
    end

    // back-to-back after one idle edge still answers
    xfer(0, 3'd0, 0, 0); xfer(0, 3'd1, 0, 0);
    chk("R8 back to back", {31'd0, r1a}, 32'd1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule